// File: doc/BRIEF.md
# CAN Message Buffer Manager

This block sits between a CAN bit-level controller and a host register bus. It holds fifteen message buffers. Each buffer can be set by the host as a receive slot or as a transmit slot. Bit timing, stuffing, CRC, error counting and bus-off handling are all left to the controller.

When the controller delivers a frame, the block decides which buffer takes it. Each buffer compares its stored identifier against the frame's identifier under an acceptance mask. Buffers 0 to 13 share one mask. Buffer 14 has a private mask, so it can act as a wide catch-all path.

On the transmit side, the block picks the pending transmit buffer with the best programmable priority and presents that frame to the controller. Remote frames are handled without host help:
- A buffer that sends a remote request turns itself into an empty receive slot, ready for the answer.
- An incoming remote request that matches a data-carrying transmit buffer schedules that buffer to send.

A 16-bit free-running counter stamps every frame that a buffer stores or sends.

Top module: `can_msgbuf_mgr`

## Requirements
- R1: After reset, every buffer control word reads 0, the lost flag reads 0, the timestamp counter starts from 0, and `tx_req` is low.
- R2: A buffer matches a frame only when its IDE bit equals the frame's IDE bit and every identifier bit whose mask bit is 1 is equal. A mask bit of 0 means that bit is ignored. Standard frames compare only identifier bits 10:0.
- R3: Buffers 0–13 compare under the global mask (global field 0). Buffer 14 compares under its own mask (global field 1).
- R4: A received data frame goes to the lowest-numbered enabled, empty, matching receive buffer. That buffer stores the frame's identifier, DLC and data (byte 0 in bits 7:0 of field 2, and field 3 holding bits 63:32), stores the counter value in field 4, and sets its flag.
- R5: A data frame that no buffer can take is dropped. No buffer changes, and the lost flag (global field 2, bit 0) sets. Any host write to global field 2 clears the lost flag.
- R6: Among enabled transmit buffers with the flag set, the block presents the one with the smallest priority value. On a tie, the lower index wins. `tx_req`, `tx_idx` and that buffer's identifier, IDE, RTR, DLC and data appear combinationally on the transmit outputs.
- R7: `tx_ack` while `tx_req` is high does two things to the presented buffer. It clears the buffer's flag, and it latches the counter value into the buffer's timestamp.
- R8: A transmit buffer whose RTR bit is set becomes a receive buffer on acknowledge. Its direction, RTR and flag bits all read 0 afterwards, and it can then accept a matching data frame.
- R9: A received remote frame does two things. It sets the flag of every enabled transmit buffer with RTR clear that matches it. It is never stored in a receive buffer and never sets the lost flag.
- R10: The timestamp counter increments by one every cycle and wraps modulo 2^16. It reads at global field 3.
- R11: A read strobed in one cycle returns its data on `host_rdata` after the next rising edge. The address is the buffer index in bits 6:3 (15 selects the globals) and the field in bits 2:0. The buffer fields are:
  - field 0: control word, with bit 0 enable, bit 1 transmit, bit 2 IDE, bit 3 RTR, bits 7:4 DLC, bits 11:8 priority, bit 12 flag;
  - field 1: identifier;
  - fields 2 and 3: data;
  - field 4: timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 7 | Buffer index (6:3) and field (2:0) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| rx_valid | input | 1 | Received frame strobe from controller |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received frame is extended |
| rx_rtr | input | 1 | Received frame is remote |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received payload |
| tx_req | output | 1 | A transmit buffer is pending |
| tx_idx | output | 4 | Index of presented buffer |
| tx_id | output | 29 | Presented identifier |
| tx_ide | output | 1 | Presented frame is extended |
| tx_rtr | output | 1 | Presented frame is remote |
| tx_dlc | output | 4 | Presented data length code |
| tx_data | output | 64 | Presented payload |
| tx_ack | input | 1 | Controller finished sending presented frame |

## Verification
The hardest situation to reach is a remote request whose answer lands back in the same slot. A transmit buffer has to send the request, flip into a receive slot on acknowledge, and then win acceptance over lower-numbered receive buffers whose masked identifiers differ. The stimulus first fills and drains neighbouring slots so that the lost path and the tie-break are already exercised. It then queues the remote buffer at priority 0 and feeds back a data frame that differs only in bits the global mask ignores. A separate long idle stretch carries the counter through its wrap.

// File: rtl/can_msgbuf_mgr.sv
module can_msgbuf_mgr #(
  parameter int NB  = 15,
  parameter int IDW = 29,
  parameter int TSW = 16,
  parameter int PW  = 4,
  parameter int IXW = 4,
  parameter int FW  = 3,
  parameter int AW  = IXW + FW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [AW-1:0]  host_addr,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata,
  input  logic           rx_valid,
  input  logic [IDW-1:0] rx_id,
  input  logic           rx_ide,
  input  logic           rx_rtr,
  input  logic [3:0]     rx_dlc,
  input  logic [63:0]    rx_data,
  output logic           tx_req,
  output logic [IXW-1:0] tx_idx,
  output logic [IDW-1:0] tx_id,
  output logic           tx_ide,
  output logic           tx_rtr,
  output logic [3:0]     tx_dlc,
  output logic [63:0]    tx_data,
  input  logic           tx_ack
);
  localparam int STDW = 11;

  logic [NB-1:0]  b_en, b_tx, b_ide, b_rtr, b_flag;
  logic [3:0]     b_dlc  [NB];
  logic [PW-1:0]  b_prio [NB];
  logic [IDW-1:0] b_id   [NB];
  logic [63:0]    b_data [NB];
  logic [TSW-1:0] b_ts   [NB];
  logic [IDW-1:0] mask_g, mask_x;
  logic           lost;
  logic [TSW-1:0] ts_cnt;

  logic           rx_any;
  logic [IXW-1:0] rx_sel;
  logic [NB-1:0]  rem_hit;

  function automatic logic id_match(input logic [IDW-1:0] a, input logic [IDW-1:0] b,
                                    input logic [IDW-1:0] m, input logic ext);
    logic [IDW-1:0] w;
    w = ext ? {IDW{1'b1}} : {{(IDW-STDW){1'b0}}, {STDW{1'b1}}};
    return ((a ^ b) & m & w) == '0;
  endfunction

  always_comb begin
    rx_any  = 1'b0;
    rx_sel  = '0;
    rem_hit = '0;
    for (int i = 0; i < NB; i++) begin
      logic hit;
      hit = b_en[i] && (b_ide[i] == rx_ide) &&
            id_match(rx_id, b_id[i], (i == NB-1) ? mask_x : mask_g, rx_ide);
      if (hit && !rx_rtr && !b_tx[i] && !b_flag[i] && !rx_any) begin
        rx_any = 1'b1;
        rx_sel = IXW'(i);
      end
      rem_hit[i] = hit && rx_rtr && b_tx[i] && !b_rtr[i];
    end
  end

  always_comb begin
    logic [PW-1:0] best;
    tx_req = 1'b0;
    tx_idx = '0;
    best   = '1;
    for (int i = 0; i < NB; i++) begin
      if (b_en[i] && b_tx[i] && b_flag[i] && (!tx_req || b_prio[i] < best)) begin
        tx_req = 1'b1;
        tx_idx = IXW'(i);
        best   = b_prio[i];
      end
    end
  end

  assign tx_id   = b_id[tx_idx];
  assign tx_ide  = b_ide[tx_idx];
  assign tx_rtr  = b_rtr[tx_idx];
  assign tx_dlc  = b_dlc[tx_idx];
  assign tx_data = b_data[tx_idx];

  wire [IXW-1:0] a_idx = host_addr[AW-1:FW];
  wire [FW-1:0]  a_fld = host_addr[FW-1:0];
  wire           a_buf = a_idx < IXW'(NB);

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (a_buf) begin
      case (a_fld)
        3'd0: rd_mux = 32'({b_flag[a_idx], b_prio[a_idx], b_dlc[a_idx],
                            b_rtr[a_idx], b_ide[a_idx], b_tx[a_idx], b_en[a_idx]});
        3'd1: rd_mux = 32'(b_id[a_idx]);
        3'd2: rd_mux = b_data[a_idx][31:0];
        3'd3: rd_mux = b_data[a_idx][63:32];
        3'd4: rd_mux = 32'(b_ts[a_idx]);
        default: rd_mux = '0;
      endcase
    end else begin
      case (a_fld)
        3'd0: rd_mux = 32'(mask_g);
        3'd1: rd_mux = 32'(mask_x);
        3'd2: rd_mux = 32'(lost);
        3'd3: rd_mux = 32'(ts_cnt);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_en <= '0; b_tx <= '0; b_ide <= '0; b_rtr <= '0; b_flag <= '0;
      for (int i = 0; i < NB; i++) begin
        b_dlc[i] <= '0; b_prio[i] <= '0; b_id[i] <= '0; b_data[i] <= '0; b_ts[i] <= '0;
      end
      mask_g <= '0;
      mask_x <= '0;
      lost   <= 1'b0;
      ts_cnt <= '0;
    end else begin
      ts_cnt <= ts_cnt + 1'b1;
      if (host_wr) begin
        if (a_buf) begin
          case (a_fld)
            3'd0: begin
              b_en[a_idx]   <= host_wdata[0];
              b_tx[a_idx]   <= host_wdata[1];
              b_ide[a_idx]  <= host_wdata[2];
              b_rtr[a_idx]  <= host_wdata[3];
              b_dlc[a_idx]  <= host_wdata[7:4];
              b_prio[a_idx] <= host_wdata[8 +: PW];
              b_flag[a_idx] <= host_wdata[8+PW];
            end
            3'd1: b_id[a_idx] <= host_wdata[IDW-1:0];
            3'd2: b_data[a_idx][31:0]  <= host_wdata;
            3'd3: b_data[a_idx][63:32] <= host_wdata;
            default: ;
          endcase
        end else begin
          case (a_fld)
            3'd0: mask_g <= host_wdata[IDW-1:0];
            3'd1: mask_x <= host_wdata[IDW-1:0];
            3'd2: lost   <= 1'b0;
            default: ;
          endcase
        end
      end
      if (rx_valid && !rx_rtr) begin
        if (rx_any) begin
          b_flag[rx_sel] <= 1'b1;
          b_id[rx_sel]   <= rx_id;
          b_dlc[rx_sel]  <= rx_dlc;
          b_data[rx_sel] <= rx_data;
          b_ts[rx_sel]   <= ts_cnt;
        end else begin
          lost <= 1'b1;
        end
      end
      if (rx_valid) begin
        for (int i = 0; i < NB; i++)
          if (rem_hit[i]) b_flag[i] <= 1'b1;
      end
      if (tx_req && tx_ack) begin
        b_flag[tx_idx] <= 1'b0;
        b_ts[tx_idx]   <= ts_cnt;
        if (b_rtr[tx_idx]) begin
          b_tx[tx_idx]  <= 1'b0;
          b_rtr[tx_idx] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/can_msgbuf_mgr_chk.sv
module can_msgbuf_mgr_chk #(
  parameter int NB  = 15,
  parameter int IXW = 4,
  parameter int TSW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           rx_rtr,
  input logic           rx_any,
  input logic [IXW-1:0] rx_sel,
  input logic           tx_req,
  input logic           tx_ack,
  input logic [IXW-1:0] tx_idx,
  input logic           tx_rtr,
  input logic [NB-1:0]  b_flag,
  input logic [NB-1:0]  b_tx,
  input logic           lost,
  input logic [TSW-1:0] ts_cnt
);
  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_rtr && rx_any |=> b_flag[$past(rx_sel)]);

  a_r5_drop_sets_lost: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_rtr && !rx_any |=> lost);

  a_r6_req_is_pending_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_idx < IXW'(NB)) && b_flag[tx_idx] && b_tx[tx_idx]);

  a_r7_ack_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack && !rx_valid |=> !b_flag[$past(tx_idx)]);

  a_r8_remote_turns_rx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack && tx_rtr |=> !b_tx[$past(tx_idx)]);

  a_r10_ts_steps: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ts_cnt == TSW'($past(ts_cnt) + 1'b1));
endmodule

bind can_msgbuf_mgr can_msgbuf_mgr_chk #(.NB(NB), .IXW(IXW), .TSW(TSW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_rtr(rx_rtr),
  .rx_any(rx_any), .rx_sel(rx_sel), .tx_req(tx_req), .tx_ack(tx_ack),
  .tx_idx(tx_idx), .tx_rtr(tx_rtr), .b_flag(b_flag), .b_tx(b_tx),
  .lost(lost), .ts_cnt(ts_cnt)
);

// File: tb/can_msgbuf_mgr_tb.sv
module can_msgbuf_mgr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        rx_valid = 1'b0, rx_ide = 1'b0, rx_rtr = 1'b0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        tx_req, tx_ide, tx_rtr;
  logic [3:0]  tx_idx, tx_dlc;
  logic [28:0] tx_id;
  logic [63:0] tx_data;
  logic        tx_ack = 1'b0;

  int errors = 0, checks = 0;
  int unsigned bc = 0;
  logic [15:0] last_ts;
  logic rd_q = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_msgbuf_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
    .rx_dlc(rx_dlc), .rx_data(rx_data), .tx_req(tx_req), .tx_idx(tx_idx),
    .tx_id(tx_id), .tx_ide(tx_ide), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc),
    .tx_data(tx_data), .tx_ack(tx_ack)
  );

  always @(posedge clk) begin
    if (!rst_n) bc <= 0; else bc <= bc + 1;
    rd_q <= host_rd;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_q) begin
      if (q_exp.size() == 0) check("R11 unexpected read data", 1, 0);
      else check(q_tag.pop_front(), {32'b0, host_rdata}, {32'b0, q_exp.pop_front()});
    end
  end

  function automatic logic [6:0] A(input int idx, input int fld);
    return {idx[3:0], fld[2:0]};
  endfunction

  function automatic logic [31:0] C(input bit en, input bit tx, input bit ide, input bit rtr,
                                    input int dlc, input int prio, input bit flag);
    return {19'b0, flag, prio[3:0], dlc[3:0], rtr, ide, tx, en};
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic rd_ts(input logic [6:0] a, input string tag);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    q_exp.push_back({16'b0, bc[15:0]}); q_tag.push_back(tag);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic send(input logic [28:0] id, input bit ide, input bit rtr,
                      input logic [3:0] dlc, input logic [63:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = d;
    last_ts = bc[15:0];
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); tx_ack = 1'b1; last_ts = bc[15:0];
    @(negedge clk); tx_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 tx_req after reset", tx_req, 0);
    rd(A(0,0), 0, "R1 buf0 ctrl");
    rd(A(14,0), 0, "R1 buf14 ctrl");
    rd(A(15,2), 0, "R1 lost");

    wr(A(15,0), 32'h7F0);
    wr(A(15,1), 32'h0);
    rd(A(15,0), 32'h7F0, "R11 global mask readback");
    wr(A(0,1), 32'h120);  wr(A(0,0), C(1,0,0,0,0,0,0));
    wr(A(1,1), 32'h120);  wr(A(1,0), C(1,0,0,0,0,0,0));
    wr(A(14,1), 32'h000); wr(A(14,0), C(1,0,0,0,0,0,0));

    send(29'h125, 0, 0, 4'd8, 64'h8877665544332211);
    rd(A(0,0), C(1,0,0,0,8,0,1), "R4 buf0 ctrl after first frame");
    rd(A(0,1), 32'h125, "R2 buf0 masked hit stores id");
    rd(A(0,2), 32'h44332211, "R4 buf0 data low");
    rd(A(0,3), 32'h88776655, "R4 buf0 data high");
    rd(A(0,4), {16'b0, last_ts}, "R4 buf0 timestamp");

    send(29'h12A, 0, 0, 4'd3, 64'h0);
    rd(A(1,0), C(1,0,0,0,3,0,1), "R4 buf1 takes frame when buf0 full");
    rd(A(1,1), 32'h12A, "R4 buf1 id");

    send(29'h300, 0, 0, 4'd0, 64'h0);
    rd(A(14,0), C(1,0,0,0,0,0,1), "R3 buf14 own mask accepts");
    rd(A(14,1), 32'h300, "R3 buf14 id");
    rd(A(15,2), 0, "R3 no loss when buf14 takes frame");

    send(29'h121, 0, 0, 4'd2, 64'hFFFF);
    rd(A(15,2), 1, "R5 lost set on drop");
    rd(A(0,1), 32'h125, "R5 buf0 unchanged by dropped frame");
    wr(A(15,2), 0);
    rd(A(15,2), 0, "R5 lost cleared by host write");

    wr(A(1,0), C(1,0,0,0,0,0,0));
    send(29'h120, 1, 0, 4'd1, 64'h0);
    rd(A(1,0), C(1,0,0,0,0,0,0), "R2 IDE mismatch not accepted");
    rd(A(15,2), 1, "R2 IDE mismatch dropped");
    wr(A(15,2), 0);

    wr(A(2,1), 32'h55); wr(A(2,2), 32'hCAFE0002); wr(A(2,3), 32'h0);
    wr(A(2,0), C(1,1,0,0,4,5,1));
    wr(A(3,1), 32'h56); wr(A(3,0), C(1,1,0,0,0,5,1));
    wr(A(4,1), 32'h57); wr(A(4,0), C(1,1,0,0,0,2,1));
    check("R6 tx_req with pending", tx_req, 1);
    check("R6 lowest priority value wins", tx_idx, 4);
    check("R6 presented id", tx_id, 29'h57);
    ack();
    rd(A(4,0), C(1,1,0,0,0,2,0), "R7 ack clears pending");
    rd(A(4,4), {16'b0, last_ts}, "R7 ack latches timestamp");
    check("R6 tie goes to lower index", tx_idx, 2);
    check("R6 presented dlc", tx_dlc, 4);
    check("R6 presented data", tx_data, 64'hCAFE0002);
    ack();
    check("R6 last pending buffer", tx_idx, 3);
    ack();
    check("R7 no pending after acks", tx_req, 0);

    wr(A(5,1), 32'h077); wr(A(5,0), C(1,1,0,1,0,0,1));
    check("R8 remote buffer presented", tx_idx, 5);
    check("R8 presented rtr", tx_rtr, 1);
    ack();
    rd(A(5,0), C(1,0,0,0,0,0,0), "R8 remote buffer now empty receive");
    send(29'h07B, 0, 0, 4'd1, 64'hAB);
    rd(A(5,0), C(1,0,0,0,1,0,1), "R8 answer stored in former remote buffer");
    rd(A(5,1), 32'h07B, "R8 answer id");
    rd(A(5,2), 32'hAB, "R8 answer data");

    wr(A(6,1), 32'h0A0); wr(A(6,0), C(1,1,0,0,2,1,0));
    check("R9 idle before remote", tx_req, 0);
    send(29'h0A3, 0, 1, 4'd0, 64'h0);
    check("R9 remote schedules buffer", tx_req, 1);
    check("R9 scheduled index", tx_idx, 6);
    check("R9 answer is data frame", tx_rtr, 0);
    rd(A(15,2), 0, "R9 remote frame does not set lost");
    rd(A(1,0), C(1,0,0,0,0,0,0), "R9 remote frame not stored");
    ack();

    rd_ts(A(15,3), "R10 counter value");
    repeat (70000) @(negedge clk);
    rd_ts(A(15,3), "R10 counter after wrap");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", q_exp.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule